// File: doc/BRIEF.md
# Weighted-Ratio Square-Wave Divider

This block divides its input clock by a ratio chosen with five static select lines and produces a square wave with equal high and low time. The ratio starts from a binary base of 2^BASE_LOG2 (2048 by default). Each asserted select multiplies it by that select's weight: a power-of-two weight (64 by default), a weight of 60, and a group of three weights (3, 10 and 30) from which at most one may be chosen. With every select asserted that is allowed, the default ratio reaches 235,929,600.

A second output copies the main square wave or its inverse, depending on a phase input. It is also given as a drive-low enable, which models an open-drain pin. A synchronous reset clears the divider. A stop input freezes the divider without losing its state. Choosing more than one weight from the group raises a lock flag and freezes the divider for as long as the conflict lasts.

Top module: `wdiv_top`

## Requirements
- R1: While `rst` is high at a clock edge, the count is cleared and `div_out` is low after that edge. After reset is released, the first rise of `div_out` comes on the H-th rising edge with `rst` low, where H is half the selected ratio.
- R2: With all five selects low, the ratio is 2^BASE_LOG2, so `div_out` changes level every 2^(BASE_LOG2-1) clocks.
- R3: Asserting exactly one select multiplies the ratio by its weight. The weights are: `sel_x64` 2^X64_LOG2, `sel_x60` W60, `sel_x3` WG0, `sel_x10` WG1, `sel_x30` WG2.
- R4: `sel_x64` and `sel_x60` may be combined with each other and with one group select (`sel_x3`, `sel_x10`, `sel_x30`). The ratio is then the product of the base and every asserted weight.
- R5: While two or more group selects are high, `sel_lock` is high and the count and `div_out` hold. Counting resumes from the held state once the conflict clears.
- R6: For every legal ratio N, `div_out` changes level only after exactly N/2 counting clocks in the current level, which gives an exact 50% duty cycle.
- R7: While `stop` is high, the count and `div_out` hold. When `stop` returns low, counting continues from the held count.
- R8: When `phase_sel` is high, `aux_out` equals `div_out`. When it is low, `aux_out` is the inverse of `div_out`.
- R9: `aux_drive_low` is high exactly when `aux_out` is low.
- R10: If a select change leaves the count at or above the new half ratio, the next counting clock clears the count to zero without changing `div_out`, and a full new half period follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high clear |
| stop | input | 1 | Freeze the count while high |
| phase_sel | input | 1 | 1: aux follows main output, 0: aux inverted |
| sel_x64 | input | 1 | Multiply the ratio by 2^X64_LOG2 |
| sel_x60 | input | 1 | Multiply the ratio by W60 |
| sel_x3 | input | 1 | Group select, weight WG0 |
| sel_x10 | input | 1 | Group select, weight WG1 |
| sel_x30 | input | 1 | Group select, weight WG2 |
| div_out | output | 1 | Square-wave divider output |
| aux_out | output | 1 | Phase-selectable copy of the output |
| aux_drive_low | output | 1 | Open-drain pull-down enable for aux |
| sel_lock | output | 1 | Illegal group combination present |

## Verification
The case that is hardest to reach is a ratio change that finds the count already past the new half period. The restart path only runs when the count is at or above the new half ratio, and that needs a long period followed by a sudden switch to a short one. The stimulus runs the weight-30 mode for most of a half period and then switches to the weight-3 mode. The bench is built with a one-bit base, which keeps the composite ratios short enough to cover whole periods.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;

    localparam int GROUP_N = 3;

    typedef struct packed {
        logic               x64;
        logic               x60;
        logic [GROUP_N-1:0] grp;   // bit0 weight WG0, bit1 WG1, bit2 WG2
    } sel_t;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_RESTART,
        ACT_STEP,
        ACT_WRAP
    } act_e;

    function automatic longint unsigned worst_half(
        input int base_log2, input int x64_log2, input int w60,
        input int wg0, input int wg1, input int wg2);
        longint unsigned gmax;
        gmax = longint'(wg0);
        if (longint'(wg1) > gmax) gmax = longint'(wg1);
        if (longint'(wg2) > gmax) gmax = longint'(wg2);
        return (longint'(1) << (base_log2 - 1 + x64_log2)) * longint'(w60) * gmax;
    endfunction

    function automatic logic grp_conflict(input logic [GROUP_N-1:0] g);
        return (g & (g - GROUP_N'(1))) != '0;
    endfunction

endpackage

// File: rtl/wdiv_sel_decode.sv
module wdiv_sel_decode
    import wdiv_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int X64_LOG2  = 6,
    parameter int W60       = 60,
    parameter int WG0       = 3,
    parameter int WG1       = 10,
    parameter int WG2       = 30,
    parameter int HALF_W    = 27
) (
    input  sel_t              sel,
    output logic [HALF_W-1:0] half,
    output logic              lock
);

    localparam int GW [GROUP_N] = '{WG0, WG1, WG2};
    localparam logic [HALF_W-1:0] BASE_HALF = HALF_W'(1) << (BASE_LOG2 - 1);

    logic [HALF_W-1:0] grp_term [GROUP_N];
    logic [HALF_W-1:0] grp_mult;
    logic [HALF_W-1:0] pow_part;
    logic [HALF_W-1:0] w60_mult;

    for (genvar g = 0; g < GROUP_N; g++) begin : g_grp
        assign grp_term[g] = sel.grp[g] ? HALF_W'(GW[g]) : '0;
    end

    always_comb begin
        grp_mult = HALF_W'(1);
        for (int i = 0; i < GROUP_N; i++) begin
            if (sel.grp[i]) grp_mult = grp_term[i];
        end
    end

    assign pow_part = sel.x64 ? (BASE_HALF << X64_LOG2) : BASE_HALF;
    assign w60_mult = sel.x60 ? HALF_W'(W60) : HALF_W'(1);
    assign half     = pow_part * w60_mult * grp_mult;
    assign lock     = grp_conflict(sel.grp);

endmodule

// File: rtl/wdiv_counter.sv
module wdiv_counter
    import wdiv_pkg::*;
#(
    parameter int HALF_W = 27
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic [HALF_W-1:0] half,
    output logic [HALF_W-1:0] cnt_q,
    output logic              wrap
);

    act_e act;

    always_comb begin
        if (hold)                       act = ACT_HOLD;
        else if (cnt_q >= half)         act = ACT_RESTART;
        else if (cnt_q == half - HALF_W'(1)) act = ACT_WRAP;
        else                            act = ACT_STEP;
    end

    assign wrap = (act == ACT_WRAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (act)
                ACT_HOLD:    cnt_q <= cnt_q;
                ACT_RESTART: cnt_q <= '0;
                ACT_WRAP:    cnt_q <= '0;
                ACT_STEP:    cnt_q <= cnt_q + HALF_W'(1);
                default:     cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/wdiv_out_stage.sv
module wdiv_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    input  logic phase_sel,
    output logic div_q,
    output logic aux,
    output logic aux_pull
);

    always_ff @(posedge clk) begin
        if (rst)       div_q <= 1'b0;
        else if (wrap) div_q <= ~div_q;
    end

    assign aux      = phase_sel ? div_q : ~div_q;
    assign aux_pull = ~aux;

endmodule

// File: rtl/wdiv_top.sv
module wdiv_top
    import wdiv_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int X64_LOG2  = 6,
    parameter int W60       = 60,
    parameter int WG0       = 3,
    parameter int WG1       = 10,
    parameter int WG2       = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic stop,
    input  logic phase_sel,
    input  logic sel_x64,
    input  logic sel_x60,
    input  logic sel_x3,
    input  logic sel_x10,
    input  logic sel_x30,
    output logic div_out,
    output logic aux_out,
    output logic aux_drive_low,
    output logic sel_lock
);

    localparam longint unsigned MAX_HALF =
        worst_half(BASE_LOG2, X64_LOG2, W60, WG0, WG1, WG2);
    localparam int HALF_W = $clog2(MAX_HALF + 1);

    sel_t              sel;
    logic [HALF_W-1:0] half_val;
    logic [HALF_W-1:0] cnt_q;
    logic              wrap;
    logic              freeze;

    assign sel.x64 = sel_x64;
    assign sel.x60 = sel_x60;
    assign sel.grp = {sel_x30, sel_x10, sel_x3};

    wdiv_sel_decode #(
        .BASE_LOG2(BASE_LOG2), .X64_LOG2(X64_LOG2), .W60(W60),
        .WG0(WG0), .WG1(WG1), .WG2(WG2), .HALF_W(HALF_W)
    ) u_dec (
        .sel  (sel),
        .half (half_val),
        .lock (sel_lock)
    );

    assign freeze = stop | sel_lock;

    wdiv_counter #(.HALF_W(HALF_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .hold  (freeze),
        .half  (half_val),
        .cnt_q (cnt_q),
        .wrap  (wrap)
    );

    wdiv_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .wrap      (wrap),
        .phase_sel (phase_sel),
        .div_q     (div_out),
        .aux       (aux_out),
        .aux_pull  (aux_drive_low)
    );

endmodule

// File: rtl/wdiv_checker.sv
module wdiv_checker #(
    parameter int HALF_W = 27
) (
    input logic              clk,
    input logic              rst,
    input logic              stop,
    input logic              phase_sel,
    input logic              div_out,
    input logic              aux_out,
    input logic              sel_lock,
    input logic [HALF_W-1:0] cnt_q,
    input logic [HALF_W-1:0] half_val
);

    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> (!div_out && cnt_q == '0));

    assert_stop_hold_R7: assert property (@(posedge clk) disable iff (rst)
        stop |=> ($stable(div_out) && $stable(cnt_q)));

    assert_lock_hold_R5: assert property (@(posedge clk) disable iff (rst)
        sel_lock |=> ($stable(div_out) && $stable(cnt_q)));

    assert_phase_R8: assert property (@(posedge clk) disable iff (rst)
        phase_sel |-> (aux_out == div_out));

    assert_toggle_at_end_R6: assert property (@(posedge clk) disable iff (rst)
        (div_out != $past(div_out)) |-> ($past(cnt_q) == $past(half_val) - HALF_W'(1)));

    assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (cnt_q >= half_val && !stop && !sel_lock) |=> (cnt_q == '0 && $stable(div_out)));

endmodule

bind wdiv_top wdiv_checker #(.HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stop      (stop),
    .phase_sel (phase_sel),
    .div_out   (div_out),
    .aux_out   (aux_out),
    .sel_lock  (sel_lock),
    .cnt_q     (cnt_q),
    .half_val  (half_val)
);

// File: tb/wdiv_top_bench.sv
module wdiv_top_bench;

    localparam int B = 1;
    localparam int WATCHDOG_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1, stop = 1'b0, phase_sel = 1'b0;
    logic sel_x64 = 1'b0, sel_x60 = 1'b0, sel_x3 = 1'b0, sel_x10 = 1'b0, sel_x30 = 1'b0;
    logic div_out, aux_out, aux_drive_low, sel_lock;

    always #5 clk = ~clk;

    wdiv_top #(.BASE_LOG2(B)) u_wdiv_top (
        .clk(clk), .rst(rst), .stop(stop), .phase_sel(phase_sel),
        .sel_x64(sel_x64), .sel_x60(sel_x60), .sel_x3(sel_x3),
        .sel_x10(sel_x10), .sel_x30(sel_x30),
        .div_out(div_out), .aux_out(aux_out),
        .aux_drive_low(aux_drive_low), .sel_lock(sel_lock)
    );

    typedef struct {
        logic  d;
        logic  a;
        logic  dl;
        logic  lk;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // reference state built from the requirements
    int   m_cnt = 0;
    logic m_out = 1'b0;

    function automatic int exp_half();
        int h, g, n;
        h = 1 << (B - 1);
        if (sel_x64) h = h * 64;
        if (sel_x60) h = h * 60;
        g = 1;
        n = 0;
        if (sel_x3)  begin g = 3;  n++; end
        if (sel_x10) begin g = 10; n++; end
        if (sel_x30) begin g = 30; n++; end
        return (n > 1) ? 0 : h * g;
    endfunction

    // driver: predict the state after the coming edge, push it, move on
    task automatic tick(input string tag);
        exp_t e;
        int   h;
        logic lk;
        h  = exp_half();
        lk = (h == 0);
        if (rst) begin
            m_cnt = 0;
            m_out = 1'b0;
        end else if (!(stop || lk)) begin
            if (m_cnt >= h) begin
                m_cnt = 0;
            end else if (m_cnt + 1 == h) begin
                m_cnt = 0;
                m_out = ~m_out;
            end else begin
                m_cnt++;
            end
        end
        e.d   = m_out;
        e.a   = phase_sel ? m_out : ~m_out;
        e.dl  = ~e.a;
        e.lk  = lk;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic set_sel(input logic a64, input logic a60,
                           input logic a3, input logic a10, input logic a30);
        sel_x64 = a64; sel_x60 = a60; sel_x3 = a3; sel_x10 = a10; sel_x30 = a30;
    endtask

    // monitor: compare after every edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (div_out !== e.d || aux_out !== e.a ||
                    aux_drive_low !== e.dl || sel_lock !== e.lk) begin
                    errors++;
                    $display("FAIL %s: got d=%b a=%b dl=%b lk=%b expected d=%b a=%b dl=%b lk=%b",
                             e.tag, div_out, aux_out, aux_drive_low, sel_lock,
                             e.d, e.a, e.dl, e.lk);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        run(3, "R1 reset");
        rst = 1'b0;
        run(8, "R2 base ratio");
        set_sel(0, 0, 1, 0, 0); run(20,  "R3 weight 3 / R6 duty");
        set_sel(0, 0, 0, 1, 0); run(40,  "R3 weight 10");
        set_sel(0, 0, 0, 0, 1); run(120, "R3 weight 30");
        set_sel(1, 0, 0, 0, 0); run(260, "R3 weight 64");
        set_sel(0, 1, 0, 0, 0); run(250, "R3 weight 60");
        set_sel(1, 0, 1, 0, 0); run(800, "R4 64x3");
        set_sel(0, 1, 0, 1, 0); run(2500, "R4 60x10");
        set_sel(1, 1, 1, 0, 0); run(25000, "R4 64x60x3");
        // restart: deep into a 30-half period, then switch to 3
        rst = 1'b1; run(2, "R1 reset again");
        rst = 1'b0;
        set_sel(0, 0, 0, 0, 1); run(25, "R10 prepare");
        set_sel(0, 0, 1, 0, 0); run(20, "R10 restart");
        // stop
        set_sel(0, 0, 0, 1, 0); run(15, "R7 before stop");
        stop = 1'b1; run(30, "R7 frozen");
        stop = 1'b0; run(30, "R7 resume");
        // lock
        set_sel(0, 0, 1, 1, 0); run(30, "R5 lock two");
        set_sel(0, 0, 0, 1, 0); run(30, "R5 resume");
        set_sel(0, 1, 1, 1, 1); run(20, "R5 lock three");
        // phase and open-drain enable
        set_sel(0, 0, 1, 0, 0);
        phase_sel = 1'b1; run(40, "R8 in phase / R9 drive");
        phase_sel = 1'b0; run(20, "R8 anti phase / R9 drive");
        // reset during a run
        rst = 1'b1; run(3, "R1 mid-run reset");
        rst = 1'b0; run(10, "R1 release");
        done = 1'b1;
        @(posedge clk); #3;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule